// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches software for a stall or a runaway loop. A down counter, slowed by a prescaler, counts from a reload value towards zero. Software must refresh the counter by writing a key value. If the counter passes below zero without a refresh, the block raises a fault. A refresh is also a fault if it comes while the counter is still at or above a programmed window limit, because a refresh that comes too early points to faulty control flow just as a late one does.

Each fault is reported in one of two ways, set by a mode bit. In interrupt mode the block sets a flag that stays high until software clears it. In reset mode it sends a request pulse one cycle long to the reset logic of the system. Configuration goes through a simple write port. The configuration fields can be locked against stray writes. A debug-halt input freezes counting while a debugger holds the processor.

Register map (word address, write data): 0 reload value in bits [11:0]; 1 window limit in bits [11:0]; 2 control, with prescaler select in [2:0], mode in [3] (1 = interrupt, 0 = reset) and enable in [4]; 3 refresh key; 4 protection key; 5 interrupt clear in bit [0].

Top module: `wdog_window`

## Requirements
- R1: After reset the counter reads 4095, the interrupt flag and the reset request are low, protection is off, the block is disabled, the reload and window limit are 4095, the prescaler select is 0 and reset mode is selected.
- R2: While enabled and not halted, the counter falls by one every 2^p clock cycles, where p is the prescaler select in control bits [2:0]. Counting starts from the reload value at the moment of enable or refresh.
- R3: When a prescaler tick arrives while the counter is 0, the block raises a fault and reloads the counter from the reload value.
- R4: A valid refresh (write of 16'hA5C3 to address 3) while the counter is greater than or equal to the window limit raises a fault. The counter still reloads.
- R5: A valid refresh while the counter is below the window limit reloads the counter and restarts the prescaler, and raises no fault.
- R6: A write to address 3 with any value other than 16'hA5C3 has no effect, and the counter keeps counting down.
- R7: In interrupt mode (control bit [3] = 1) a fault sets the interrupt flag and leaves the reset request low. In reset mode (bit [3] = 0) a fault drives the reset request high for exactly one cycle and leaves the interrupt flag unchanged.
- R8: The interrupt flag stays set until a write to address 5 with bit [0] = 1. If a clear and a new fault fall in the same cycle, the flag stays set.
- R9: While the debug-halt input is high, neither the counter nor the prescaler advances.
- R10: A write of 16'h7E19 to address 4 turns protection off. Any other value written there turns it on. While protection is on, writes to addresses 0, 1 and 2 are ignored.
- R11: While disabled (control bit [4] = 0), the counter holds the reload value, refreshes are ignored and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 3 | Register word address |
| wr_data_i | input | 16 | Register write data |
| dbg_halt_i | input | 1 | Debug halt; freezes counting while high |
| count_o | output | 12 | Current counter value |
| irq_o | output | 1 | Sticky fault interrupt flag |
| rst_req_o | output | 1 | One-cycle system reset request |
| locked_o | output | 1 | High while configuration protection is on |

## Verification
The bench probes both edges of the refresh window. It checks a refresh with the counter exactly at the limit and one just below it, so a design that compares with the wrong relational operator faults on the wrong side. It places the underflow to the exact cycle for several prescaler settings. A tick decoded off by one, or a prescaler that is not restarted on refresh, therefore shows up as a wrong count or a fault in the wrong cycle. Under protection it tries to disable the block and to change the reload value, and then reads the effect back through the count. A lock that leaks lets the count stop or reload to the new value. Random trials mix reload values, window limits, prescaler settings and refresh times.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    parameter int unsigned CNT_W  = 12;
    parameter int unsigned PSC_W  = 3;
    parameter int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_RELOAD = 3'd0;
    localparam logic [ADDR_W-1:0] REG_DELTA  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] REG_FEED   = 3'd3;
    localparam logic [ADDR_W-1:0] REG_GUARD  = 3'd4;
    localparam logic [ADDR_W-1:0] REG_ACK    = 3'd5;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] delta;
        logic [PSC_W-1:0] psel;
        logic             irq_mode;
        logic             enable;
    } cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned     DATA_W     = 16,
    parameter logic [DATA_W-1:0] FEED_KEY   = 16'hA5C3,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 16'h7E19
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output cfg_t              cfg_o,
    output logic              locked_o,
    output logic              feed_o,
    output logic              ack_o
);
    typedef struct packed {
        cfg_t cfg;
        logic locked;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        feed_o = 1'b0;
        ack_o  = 1'b0;
        if (wr_en_i) begin
            case (wr_addr_i)
                REG_RELOAD: if (!st_q.locked) st_d.cfg.reload = wr_data_i[CNT_W-1:0];
                REG_DELTA:  if (!st_q.locked) st_d.cfg.delta  = wr_data_i[CNT_W-1:0];
                REG_CTRL: begin
                    if (!st_q.locked) begin
                        st_d.cfg.psel     = wr_data_i[PSC_W-1:0];
                        st_d.cfg.irq_mode = wr_data_i[PSC_W];
                        st_d.cfg.enable   = wr_data_i[PSC_W+1];
                    end
                end
                REG_FEED:  feed_o      = (wr_data_i == FEED_KEY);
                REG_GUARD: st_d.locked = (wr_data_i != UNLOCK_KEY);
                REG_ACK:   ack_o       = wr_data_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cfg.reload   <= '1;
            st_q.cfg.delta    <= '1;
            st_q.cfg.psel     <= '0;
            st_q.cfg.irq_mode <= 1'b0;
            st_q.cfg.enable   <= 1'b0;
            st_q.locked       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o    = st_q.cfg;
    assign locked_o = st_q.locked;
endmodule

// File: rtl/wdog_presc.sv
module wdog_presc #(
    parameter int unsigned PSC_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] psel_i,
    output logic             tick_o
);
    localparam int unsigned DIV_W = (1 << PSC_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } st_t;

    st_t              st_d, st_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(psel_i));
        end
        tick_o = run_i && ((st_q.div & mask) == mask);
        st_d   = st_q;
        if (restart_i) begin
            st_d.div = '0;
        end else if (run_i) begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.div <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             irq_mode_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] delta_i,
    input  logic             tick_i,
    input  logic             feed_i,
    input  logic             ack_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             rst_req_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rst;
    } st_t;

    st_t  st_d, st_q;
    logic fault;

    always_comb begin
        st_d     = st_q;
        st_d.rst = 1'b0;
        fault    = 1'b0;
        if (!enable_i) begin
            st_d.cnt = reload_i;
        end else if (feed_i) begin
            st_d.cnt = reload_i;
            fault    = (st_q.cnt >= delta_i);
        end else if (tick_i) begin
            if (st_q.cnt == '0) begin
                fault    = 1'b1;
                st_d.cnt = reload_i;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (ack_i) begin
            st_d.irq = 1'b0;
        end
        if (fault) begin
            if (irq_mode_i) st_d.irq = 1'b1;
            else            st_d.rst = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= '1;
            st_q.irq <= 1'b0;
            st_q.rst <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign irq_o     = st_q.irq;
    assign rst_req_o = st_q.rst;
endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdog_pkg::*;
#(
    parameter int unsigned       DATA_W     = 16,
    parameter logic [DATA_W-1:0] FEED_KEY   = 16'hA5C3,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 16'h7E19
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [15:0]       wr_data_i,
    input  logic              dbg_halt_i,
    output logic [11:0]       count_o,
    output logic              irq_o,
    output logic              rst_req_o,
    output logic              locked_o
);
    cfg_t cfg_w;
    logic feed_w;
    logic ack_w;
    logic tick_w;
    logic run_w;
    logic restart_w;

    wdog_regs #(
        .DATA_W    (DATA_W),
        .FEED_KEY  (FEED_KEY),
        .UNLOCK_KEY(UNLOCK_KEY)
    ) regs_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .cfg_o    (cfg_w),
        .locked_o (locked_o),
        .feed_o   (feed_w),
        .ack_o    (ack_w)
    );

    assign run_w     = cfg_w.enable && !dbg_halt_i;
    assign restart_w = feed_w || !cfg_w.enable;

    wdog_presc #(
        .PSC_W(PSC_W)
    ) presc_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_w),
        .restart_i(restart_w),
        .psel_i   (cfg_w.psel),
        .tick_o   (tick_w)
    );

    wdog_cnt #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .enable_i  (cfg_w.enable),
        .irq_mode_i(cfg_w.irq_mode),
        .reload_i  (cfg_w.reload),
        .delta_i   (cfg_w.delta),
        .tick_i    (tick_w),
        .feed_i    (feed_w),
        .ack_i     (ack_w),
        .cnt_o     (count_o),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk
    import wdog_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             dbg_halt_i,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_o,
    input logic             rst_req_o,
    input logic             locked_o,
    input cfg_t             cfg,
    input logic             feed,
    input logic             ack
);
    AST_LOCKED_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |=> $stable(cfg)); // R10

    AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !ack) |=> irq_o); // R8

    AST_ONE_FAULT_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rst_req_o && $rose(irq_o))); // R7

    AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg.enable && $past(cfg.enable) && !$past(feed) && ($past(count_o) != '0))
        |-> ((count_o == $past(count_o)) || (count_o == $past(count_o) - CNT_W'(1)))); // R2

    AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(dbg_halt_i) && $past(cfg.enable) && cfg.enable && !$past(feed))
        |-> $stable(count_o)); // R9

    AST_EARLY_FEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (feed && cfg.enable && (count_o >= cfg.delta)) |=> (irq_o || rst_req_o)); // R4

    AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg.enable |=> !rst_req_o); // R11
endmodule

bind wdog_window wdog_window_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dbg_halt_i(dbg_halt_i),
    .count_o   (count_o),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o),
    .locked_o  (locked_o),
    .cfg       (cfg_w),
    .feed      (feed_w),
    .ack       (ack_w)
);

// File: tb/wdog_window_tb_top.sv
module wdog_window_tb_top;
    localparam logic [15:0] FEED = 16'hA5C3;
    localparam logic [15:0] UNLK = 16'h7E19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        halt = 1'b0;
    logic [11:0] count;
    logic        irq, rst_req, locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wdog_window dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .dbg_halt_i(halt),
        .count_o   (count),
        .irq_o     (irq),
        .rst_req_o (rst_req),
        .locked_o  (locked)
    );

    function automatic int exp_cnt(int r, int p, int k);
        return r - (k >> p);
    endfunction

    function automatic int exp_fault(int c, int dl);
        return (c >= dl) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write lands
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input int r, input int dl, input int p, input int mode);
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'(r));
        wr(3'd1, 16'(dl));
        wr(3'd5, 16'h0001);
        wr(3'd2, 16'((1 << 4) | (mode << 3) | p));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 count", count, 4095);
        chk("R1 irq", irq, 0);
        chk("R1 rst", rst_req, 0);
        chk("R1 locked", locked, 0);

        // R11: refresh while disabled
        wr(3'd3, FEED);
        chk("R11 irq", irq, 0);
        chk("R11 rst", rst_req, 0);
        idle(5);
        chk("R11 count held", count, 4095);

        // R2 prescaler 2^2
        setup(20, 4095, 2, 1);
        idle(9);
        chk("R2 p2 k9", count, exp_cnt(20, 2, 9));
        idle(3);
        chk("R2 p2 k12", count, exp_cnt(20, 2, 12));

        // R3 underflow in interrupt mode
        setup(3, 4095, 1, 1);
        idle(7);
        chk("R3 at zero", count, 0);
        chk("R3 no early irq", irq, 0);
        idle(1);
        chk("R3 irq", irq, 1);
        chk("R3 reload", count, 3);
        chk("R7 irq mode no rst", rst_req, 0);
        idle(5);
        chk("R8 sticky", irq, 1);
        wr(3'd5, 16'h0001);
        chk("R8 cleared", irq, 0);

        // R7 reset mode
        setup(3, 4095, 1, 0);
        idle(8);
        chk("R7 rst pulse", rst_req, 1);
        chk("R7 no irq", irq, 0);
        chk("R3 reload rst mode", count, 3);
        idle(1);
        chk("R7 pulse one cycle", rst_req, 0);

        // R5 refresh just below limit
        setup(10, 5, 0, 1);
        idle(6);
        chk("R5 pre", count, 4);
        wr(3'd3, FEED);
        chk("R5 reload", count, 10);
        chk("R5 no fault", irq, 0);
        idle(3);
        chk("R5 prescaler restart", count, 7);

        // R4 refresh at the limit
        setup(10, 5, 0, 1);
        idle(5);
        chk("R4 pre", count, 5);
        wr(3'd3, FEED);
        chk("R4 fault", irq, 1);
        chk("R4 reload", count, 10);

        // R6 wrong key
        setup(10, 4095, 0, 1);
        idle(3);
        wr(3'd3, 16'h1234);
        chk("R6 count", count, 6);
        chk("R6 no fault", irq, 0);

        // R9 halt
        setup(20, 4095, 0, 1);
        idle(2);
        halt = 1'b1;
        idle(5);
        chk("R9 frozen", count, 18);
        halt = 1'b0;
        idle(3);
        chk("R9 resumed", count, 15);

        // R10 protection
        setup(10, 4095, 0, 1);
        wr(3'd4, 16'h0000);
        chk("R10 locked", locked, 1);
        wr(3'd0, 16'd30);
        wr(3'd2, 16'h0000);
        chk("R10 disable ignored", count, 7);
        wr(3'd4, UNLK);
        chk("R10 unlocked", locked, 0);
        wr(3'd2, 16'h0000);
        idle(1);
        chk("R10 reload kept", count, 10);

        // random trials
        for (int t = 0; t < 40; t++) begin
            int r, p, dl, k, c;
            r  = 8 + int'($urandom % 40);
            p  = int'($urandom % 3);
            dl = int'($urandom % (r + 2));
            k  = int'($urandom % (r << p));
            setup(r, dl, p, 1);
            idle(k);
            c = exp_cnt(r, p, k);
            chk("R2 random count", count, c);
            wr(3'd3, FEED);
            chk("R5 random reload", count, r);
            chk("R4 random window", irq, exp_fault(c, dl));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule